// File: doc/BRIEF.md
# Streaming Set Sum Reducer

This block turns a stream of numbers, grouped into sets of varying length, into one total per set. Values arrive one per clock on `inValid`/`inData`, and `inLast` marks the final value of a set. The block never stalls the source. The next set may begin on the clock right after the previous set's last value. Each total appears on `outValid`/`outData` as a single-cycle pulse, and totals leave in the same order as their sets arrived.

All additions go through one shared integer adder, which has a fixed pipeline latency (`LAT`, default 3). Every cycle a controller looks at four possible operand sources: the new input, a first holding register, a second holding register, and the result leaving the adder pipeline. It picks two items that belong to the same set and feeds them to the adder. It also picks the item, if any, that is the finished total of a closed set. Whatever is left over goes into the two holding registers. Every item carries a one-bit set tag, so partial sums of neighbouring sets never mix. A per-tag item count tells when a closed set has collapsed to a single item, which is its total. Arithmetic is modulo 2^`DATA_W`, so results are exact.

Sets shorter than eight values are outside the supported range. So is a source that cannot keep pace.

Top module: `stream_set_reducer`

## Requirements
- R1: While `rst` is high, and on the cycle after any clock edge that samples it high, `outValid` is 0. Reset discards all partial sums and any unfinished set.
- R2: For every set of at least 8 values, exactly one pulse appears on `outValid`. `outData` equals the sum of that set's values modulo 2^`DATA_W`.
- R3: Totals are emitted in the order in which their sets were closed by `inLast`.
- R4: A new set may start on the cycle right after the previous set's last value, with no idle cycle. No value is ever refused or lost.
- R5: A set's total appears no more than 20 clock edges after the edge that accepts its last value.
- R6: `outValid` is never high on two consecutive cycles. It is never high without a matching closed set, so no total is duplicated and none is spurious.
- R7: The adder only ever combines two items carrying the same set tag.
- R8: After each cycle's addition and emission, at most two items remain to be held. The two holding registers never overflow.
- R9: Sums that exceed 2^`DATA_W` wrap around and are not saturated.
- R10: Idle cycles (`inValid` low), both inside a set and between sets, do not change any total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A value is presented on `inData` this cycle |
| inData | input | DATA_W | Value to accumulate |
| inLast | input | 1 | Qualified by `inValid`: this value closes its set |
| outValid | output | 1 | One-cycle pulse: `outData` holds a finished set total |
| outData | output | DATA_W | Set total, modulo 2^DATA_W |

## Verification
The hardest cycles are those in which the first values of a new set arrive while the previous set's partial sums are still leaving the adder. In those cycles the controller must fold the old set, pair or hold the new inputs, and sometimes also emit the old total, all at once. The bench provokes this by driving runs of eight-value sets back to back with no gap, alongside longer sets and sets separated by gaps. Each total is judged against an independently computed sum, in order, within a latency bound. A set built from large values checks that the sum wraps. A checker verifies on every cycle that operands share a tag and that leftover items fit in the two holding registers.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int SLOTS  = 4;
  localparam int SLOT_W = $clog2(SLOTS);

  typedef logic [SLOT_W-1:0] slotIdx_t;

  // Operand source slots; lower index wins when searching for a pair
  localparam slotIdx_t SL_IB   = 2'd0;
  localparam slotIdx_t SL_OB   = 2'd1;
  localparam slotIdx_t SL_IN   = 2'd2;
  localparam slotIdx_t SL_PIPE = 2'd3;

  typedef struct packed {
    logic     inTag;
    logic     addEn;
    slotIdx_t opA;
    slotIdx_t opB;
    logic     emitEn;
    slotIdx_t emitSel;
    logic     ibLoad;
    slotIdx_t ibSel;
    logic     obLoad;
    slotIdx_t obSel;
  } ctrlStrobe_t;

  typedef struct packed {
    logic ibValid;
    logic ibTag;
    logic obValid;
    logic obTag;
    logic pipeValid;
    logic pipeTag;
  } pathStatus_t;
endpackage

// File: rtl/sfr_datapath.sv
module sfr_datapath
  import sfr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  ctrlStrobe_t       strb,
  output pathStatus_t       stat,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] ibData, obData;
  logic              ibValid, ibTag, obValid, obTag;

  logic              stV [LAT];
  logic              stT [LAT];
  logic [DATA_W-1:0] stD [LAT];

  logic [DATA_W-1:0] slotD [SLOTS];
  logic [SLOTS-1:0]  slotT;
  logic [DATA_W-1:0] sum;

  always_comb begin
    slotD[SL_IB]   = ibData;
    slotD[SL_OB]   = obData;
    slotD[SL_IN]   = inData;
    slotD[SL_PIPE] = stD[LAT-1];
    slotT[SL_IB]   = ibTag;
    slotT[SL_OB]   = obTag;
    slotT[SL_IN]   = strb.inTag;
    slotT[SL_PIPE] = stT[LAT-1];
  end

  assign sum = slotD[strb.opA] + slotD[strb.opB];

  // Adder pipeline: the sum is registered, then shifted through LAT-1 more stages
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LAT; k++) stV[k] <= 1'b0;
    end else begin
      stV[0] <= strb.addEn;
      for (int k = 1; k < LAT; k++) stV[k] <= stV[k-1];
    end
    stT[0] <= slotT[strb.opA];
    stD[0] <= sum;
    for (int k = 1; k < LAT; k++) begin
      stT[k] <= stT[k-1];
      stD[k] <= stD[k-1];
    end
  end

  // Holding registers: rewritten every cycle with whatever is left over
  always_ff @(posedge clk) begin
    if (rst) begin
      ibValid  <= 1'b0;
      obValid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      ibValid  <= strb.ibLoad;
      obValid  <= strb.obLoad;
      outValid <= strb.emitEn;
    end
    ibData  <= slotD[strb.ibSel];
    ibTag   <= slotT[strb.ibSel];
    obData  <= slotD[strb.obSel];
    obTag   <= slotT[strb.obSel];
    outData <= slotD[strb.emitSel];
  end

  always_comb begin
    stat.ibValid   = ibValid;
    stat.ibTag     = ibTag;
    stat.obValid   = obValid;
    stat.obTag     = obTag;
    stat.pipeValid = stV[LAT-1];
    stat.pipeTag   = stT[LAT-1];
  end
endmodule

// File: rtl/sfr_control.sv
module sfr_control
  import sfr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inLast,
  input  pathStatus_t stat,
  output ctrlStrobe_t strb
);
  logic             curTag;
  logic [1:0]       closed;
  logic [CNT_W-1:0] cnt     [2];
  logic [CNT_W-1:0] cntNext [2];

  logic [SLOTS-1:0] v, t, inPair;
  logic             pairFound, pairTag, emitTag;
  slotIdx_t         opA, opB;

  assign v = {stat.pipeValid, inValid, stat.obValid, stat.ibValid};
  assign t = {stat.pipeTag,   curTag,  stat.obTag,   stat.ibTag};

  // Pair search: the older set's items are folded first
  always_comb begin
    logic wantTag;
    pairFound = 1'b0;
    pairTag   = 1'b0;
    opA       = SL_IB;
    opB       = SL_OB;
    for (int k = 0; k < 2; k++) begin
      wantTag = (k == 0) ? !curTag : curTag;
      for (int i = 0; i < SLOTS; i++) begin
        for (int j = i + 1; j < SLOTS; j++) begin
          if (!pairFound && v[i] && v[j] && t[i] == wantTag && t[j] == wantTag) begin
            pairFound = 1'b1;
            pairTag   = wantTag;
            opA       = slotIdx_t'(i);
            opB       = slotIdx_t'(j);
          end
        end
      end
    end
    for (int i = 0; i < SLOTS; i++)
      inPair[i] = pairFound && (slotIdx_t'(i) == opA || slotIdx_t'(i) == opB);
  end

  // Emission and leftover placement
  always_comb begin
    strb         = '0;
    strb.inTag   = curTag;
    strb.addEn   = pairFound;
    strb.opA     = opA;
    strb.opB     = opB;
    emitTag      = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!strb.emitEn && v[i] && !inPair[i] && closed[t[i]] &&
          cnt[t[i]] == CNT_W'(1)) begin
        strb.emitEn  = 1'b1;
        strb.emitSel = slotIdx_t'(i);
        emitTag      = t[i];
      end
    end
    for (int i = 0; i < SLOTS; i++) begin
      if (v[i] && !inPair[i] && !(strb.emitEn && strb.emitSel == slotIdx_t'(i))) begin
        if (!strb.ibLoad) begin
          strb.ibLoad = 1'b1;
          strb.ibSel  = slotIdx_t'(i);
        end else if (!strb.obLoad) begin
          strb.obLoad = 1'b1;
          strb.obSel  = slotIdx_t'(i);
        end
      end
    end
  end

  // Items per tag: +1 per accepted input, -1 per addition
  always_comb begin
    for (int g = 0; g < 2; g++) begin
      cntNext[g] = cnt[g]
                 + CNT_W'(inValid && curTag == 1'(g))
                 - CNT_W'(pairFound && pairTag == 1'(g));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curTag <= 1'b0;
      closed <= '0;
      for (int g = 0; g < 2; g++) cnt[g] <= '0;
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (strb.emitEn && emitTag == 1'(g)) begin
          cnt[g]    <= '0;
          closed[g] <= 1'b0;
        end else begin
          cnt[g] <= cntNext[g];
          if (inValid && inLast && curTag == 1'(g)) closed[g] <= 1'b1;
        end
      end
      if (inValid && inLast) curTag <= !curTag;
    end
  end
endmodule

// File: rtl/stream_set_reducer.sv
module stream_set_reducer
  import sfr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  // Live items of one set never exceed pipeline depth plus buffers plus input
  localparam int CNT_W = $clog2(LAT + SLOTS + 1) + 1;

  ctrlStrobe_t strb;
  pathStatus_t stat;

  sfr_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .inValid(inValid),
    .inLast (inLast),
    .stat   (stat),
    .strb   (strb)
  );

  sfr_datapath #(.DATA_W(DATA_W), .LAT(LAT)) u_path (
    .clk     (clk),
    .rst     (rst),
    .inData  (inData),
    .strb    (strb),
    .stat    (stat),
    .outValid(outValid),
    .outData (outData)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker
  import sfr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        outValid,
  input ctrlStrobe_t strb,
  input pathStatus_t stat
);
  logic [SLOTS-1:0] vv, tt;
  int               spent;

  assign vv    = {stat.pipeValid, inValid, stat.obValid, stat.ibValid};
  assign tt    = {stat.pipeTag, strb.inTag, stat.obTag, stat.ibTag};
  assign spent = (strb.addEn ? 2 : 0) + (strb.emitEn ? 1 : 0);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(vv) <= spent + 2);

  // R7
  tag_isolation_chk: assert property (@(posedge clk) disable iff (rst)
    strb.addEn |-> (strb.opA != strb.opB && vv[strb.opA] && vv[strb.opB] &&
                    tt[strb.opA] == tt[strb.opB]));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R6
  out_has_source_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(strb.emitEn));

  // R2
  emit_live_item_chk: assert property (@(posedge clk) disable iff (rst)
    strb.emitEn |-> (vv[strb.emitSel] &&
                     !(strb.addEn && (strb.emitSel == strb.opA || strb.emitSel == strb.opB))));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !outValid);
endmodule

bind stream_set_reducer sfr_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .outValid(outValid),
  .strb    (strb),
  .stat    (stat)
);

// File: tb/sim_stream_set_reducer.sv
module sim_stream_set_reducer;
  localparam int DATA_W  = 32;
  localparam int NSETS   = 12;
  localparam int MAX_LAT = 20;

  // Stimulus table: set length, base value, idle cycles before the set
  localparam int          LEN  [NSETS] = '{8, 8, 8, 9, 12, 8, 20, 8, 10, 8, 11, 8};
  localparam logic [31:0] BASE [NSETS] = '{32'd1, 32'd100, 32'd7, 32'd5000, 32'd3,
                                           32'hF000_0000, 32'd42, 32'd0, 32'd999,
                                           32'd12, 32'd77, 32'd250};
  localparam int          GAP  [NSETS] = '{0, 0, 0, 0, 0, 0, 0, 3, 0, 1, 0, 0};
  localparam int          WRAP_SET = 5;

  logic              clk = 1'b0;
  logic              rst;
  logic              inValid, inLast;
  logic [DATA_W-1:0] inData;
  logic              outValid;
  logic [DATA_W-1:0] outData;

  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  int          got = 0;
  int          expCount = 0;
  bit          monOn = 1'b0;
  logic [31:0] expSum  [NSETS+1];
  int          lastCyc [NSETS+1];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stream_set_reducer #(.DATA_W(DATA_W), .LAT(3)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .inLast(inLast), .outValid(outValid), .outData(outData)
  );

  function automatic logic [31:0] elem(input int s, input int i, input logic [31:0] base);
    return base + 32'(i) * 32'h0000_9E37 + 32'(s) * 32'(i);
  endfunction

  task automatic sendSet(input int s, input int len, input int gap,
                         input logic [31:0] base, input int gapMid);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); inValid = 1'b0; inLast = 1'b0;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData  = elem(s, i, base);
      inLast  = (i == len - 1);
      if (i == len - 1) lastCyc[s] = cyc + 1;
      if (gapMid > 0 && i == len / 2) begin
        @(negedge clk); inValid = 1'b0; inLast = 1'b0;
        @(negedge clk); inValid = 1'b0;
      end
    end
  endtask

  // Output monitor, sampled between edges
  always @(negedge clk) begin
    if (monOn && !rst && outValid) begin
      checks++;
      if (got >= expCount) begin
        errors++;
        $display("FAIL R6 spurious total: got %h, expected no output (count %0d of %0d)",
                 outData, got + 1, expCount);
      end else begin
        // R2 R3 R4 R7 R9 R10: exact sum, in set order
        if (outData !== expSum[got]) begin
          errors++;
          $display("FAIL R2 R3 R7 R9 set %0d: total %h, expected %h", got, outData, expSum[got]);
        end
        checks++;
        // R5
        if (cyc - lastCyc[got] > MAX_LAT || cyc - lastCyc[got] < 1) begin
          errors++;
          $display("FAIL R5 set %0d: latency %0d, expected 1..%0d",
                   got, cyc - lastCyc[got], MAX_LAT);
        end
      end
      got++;
    end
  end

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired: totals %0d, expected %0d", got, expCount);
    finishRun();
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; inLast = 1'b0; inData = '0;
    for (int s = 0; s < NSETS; s++) begin
      expSum[s] = '0;
      for (int i = 0; i < LEN[s]; i++) expSum[s] = expSum[s] + elem(s, i, BASE[s]);
    end
    expSum[NSETS] = '0;
    for (int i = 0; i < 8; i++) expSum[NSETS] = expSum[NSETS] + elem(NSETS, i, 32'd31);

    repeat (3) @(negedge clk);
    checks++;
    // R1: quiet output under reset
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 outValid during reset: %b, expected 0", outValid);
    end
    rst = 1'b0;
    expCount = NSETS;
    monOn = 1'b1;

    // Main table walk: back-to-back sets (R4), idle gaps (R10), wrap set (R9)
    for (int s = 0; s < NSETS; s++)
      sendSet(s, LEN[s], GAP[s], BASE[s], (s == 9) ? 1 : 0);
    @(negedge clk); inValid = 1'b0; inLast = 1'b0;
    repeat (40) @(negedge clk);

    checks++;
    // R2 R6 R8: every set produced exactly one total
    if (got != NSETS) begin
      errors++;
      $display("FAIL R2 R6 total count %0d, expected %0d", got, NSETS);
    end
    if (WRAP_SET >= NSETS) errors++;

    // Directed: reset in the middle of an unfinished set
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); inValid = 1'b1; inLast = 1'b0; inData = 32'h5555_0000 + 32'(i);
    end
    @(negedge clk); inValid = 1'b0; rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checks++;
    // R1
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 outValid after mid-set reset: %b, expected 0", outValid);
    end
    rst = 1'b0;
    expCount = NSETS + 1;
    sendSet(NSETS, 8, 0, 32'd31, 0);
    @(negedge clk); inValid = 1'b0; inLast = 1'b0;
    repeat (40) @(negedge clk);
    checks++;
    // R1 R2: only the fresh set's total, discarded values not included
    if (got != NSETS + 1) begin
      errors++;
      $display("FAIL R1 R2 totals after reset %0d, expected %0d", got, NSETS + 1);
    end
    finishRun();
  end
endmodule